// File: doc/BRIEF.md
# 64-bit SEC-DED Syndrome Decoder

This block checks a 64-bit word against the 8-bit check byte stored with it and repairs a single fault. It recomputes the check byte from the received data using a fixed parity matrix. It XORs that result with the received check byte to form an 8-bit syndrome. It then sorts the syndrome into one of four outcomes: clean, one bad data bit, one bad check bit, or uncorrectable.

The parity matrix is not a textbook Hamming layout. Because of that, the data-bit columns are searched first, and the lowest-numbered data bit whose column equals the syndrome is taken as the fault. A check-bit fault is only reported when no data column matches and the syndrome has exactly one bit set.

The result is registered. A pulse on the input strobe is answered one clock later with the outcome, the failing bit position, the repaired data word and the repaired check byte.

Top module: `secded_decoder`

## Requirements
- R1: Check bit i (0..7) is the even parity of the data bits picked out by a pair of 32-bit masks. The high mask applies to data[63:32] and the low mask to data[31:0], with mask bit j selecting bit j of that half. The high/low pairs, in hex, from check bit 0 upwards, are: f00fe11e/c33c0ff7, 00ff00ff/00fff0ff, 0f0f0f0f/0f0fff00, 11113333/7777000f, 22224444/8888222f, 44448888/ffff4441, 8888ffff/11118882, ffff1111/22221114.
- R2: The syndrome is the recomputed check byte XOR in_check. A zero syndrome gives out_status 0 (clean) and out_pos 0, with data and check byte passed through unchanged.
- R3: The column of data bit b is the byte whose bit i is bit (b mod 32) of check bit i's low mask (b < 32) or high mask (b >= 32). If the syndrome equals one or more data columns, the lowest such b wins. The outcome is out_status 1, out_pos = b, out_data = data with bit b inverted, and out_check = in_check.
- R4: If no data column matches and exactly one syndrome bit k is set, the outcome is out_status 2, out_pos = k, out_check = in_check with bit k inverted, and out_data = in_data.
- R5: If no data column matches and two or more syndrome bits are set, the outcome is out_status 3, out_pos 0, with data and check byte returned unchanged.
- R6: out_valid rises exactly one clock after a cycle with in_valid high. In a cycle with in_valid low, out_valid is 0 one clock later and the result outputs keep their values.
- R7: While rst_n is low, out_valid, out_status, out_pos, out_data and out_check are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 64 | Received data word |
| in_check | input | 8 | Received check byte |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_status | output | 2 | 0 clean, 1 data-bit fault, 2 check-bit fault, 3 uncorrectable |
| out_pos | output | 6 | Index of the faulty data or check bit |
| out_data | output | 64 | Repaired data word |
| out_check | output | 8 | Repaired check byte |

## Verification
The matrix fixes the word at 64 data bits and 8 check bits, so the bench builds the block at its default widths. That size is small enough to sweep every single data-bit flip and every single check-bit flip over several base words. It also covers adjacent double flips and mixed data/check double flips, which reach the lowest-match priority and the uncorrectable path. The bench rebuilds each column as the parity of a one-hot word and redoes the search in its own model.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int POS_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_DATA   = 2'd1,
    FLT_CHECK  = 2'd2,
    FLT_UNCORR = 2'd3
  } fault_e;

  // Selection masks per check bit, index = check bit number
  localparam logic [HALF_W-1:0] HI_SEL [CHK_W] = '{
    32'hf00fe11e, 32'h00ff00ff, 32'h0f0f0f0f, 32'h11113333,
    32'h22224444, 32'h44448888, 32'h8888ffff, 32'hffff1111
  };
  localparam logic [HALF_W-1:0] LO_SEL [CHK_W] = '{
    32'hc33c0ff7, 32'h00fff0ff, 32'h0f0fff00, 32'h7777000f,
    32'h8888222f, 32'hffff4441, 32'h11118882, 32'h22221114
  };

  // Recompute the check byte of a word
  function automatic logic [CHK_W-1:0] calc_check(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] r;
    for (int i = 0; i < CHK_W; i++)
      r[i] = (^(d[DATA_W-1:HALF_W] & HI_SEL[i])) ^ (^(d[HALF_W-1:0] & LO_SEL[i]));
    return r;
  endfunction

  // Syndrome produced by a fault on data bit b
  function automatic logic [CHK_W-1:0] data_column(input int b);
    logic [CHK_W-1:0] r;
    for (int i = 0; i < CHK_W; i++)
      r[i] = (b >= HALF_W) ? HI_SEL[i][b - HALF_W] : LO_SEL[i][b];
    return r;
  endfunction
endpackage

// File: rtl/secded_chk_gen.sv
module secded_chk_gen
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);
  for (genvar g = 0; g < CHK_W; g++) begin : g_bit
    assign check[g] = (^(data[DATA_W-1:HALF_W] & HI_SEL[g])) ^
                      (^(data[HALF_W-1:0] & LO_SEL[g]));
  end
endmodule

// File: rtl/secded_col_match.sv
module secded_col_match
  import secded_pkg::*;
(
  input  logic [CHK_W-1:0] syndrome,
  output logic             hit_any,
  output logic [POS_W-1:0] hit_pos
);
  logic [DATA_W-1:0] hit;

  for (genvar b = 0; b < DATA_W; b++) begin : g_col
    localparam logic [CHK_W-1:0] COL = data_column(b);
    assign hit[b] = (syndrome == COL);
  end

  // lowest matching index wins
  always_comb begin
    hit_pos = '0;
    for (int b = DATA_W - 1; b >= 0; b--)
      if (hit[b]) hit_pos = POS_W'(b);
  end

  assign hit_any = |hit;
endmodule

// File: rtl/secded_classify.sv
module secded_classify
  import secded_pkg::*;
(
  input  logic [CHK_W-1:0] syndrome,
  input  logic             hit_any,
  input  logic [POS_W-1:0] hit_pos,
  output fault_e           status,
  output logic [POS_W-1:0] pos
);
  logic [POS_W-1:0] low_set;
  logic [$clog2(CHK_W+1)-1:0] weight;

  always_comb begin
    low_set = '0;
    for (int k = CHK_W - 1; k >= 0; k--)
      if (syndrome[k]) low_set = POS_W'(k);
  end

  always_comb begin
    weight = '0;
    for (int k = 0; k < CHK_W; k++)
      weight = weight + syndrome[k];
  end

  always_comb begin
    if (syndrome == '0) begin
      status = FLT_NONE;
      pos    = '0;
    end else if (hit_any) begin
      status = FLT_DATA;
      pos    = hit_pos;
    end else if (weight == 1) begin
      status = FLT_CHECK;
      pos    = low_set;
    end else begin
      status = FLT_UNCORR;
      pos    = '0;
    end
  end
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [63:0]       in_data,
  input  logic [7:0]        in_check,
  output logic              out_valid,
  output logic [1:0]        out_status,
  output logic [5:0]        out_pos,
  output logic [63:0]       out_data,
  output logic [7:0]        out_check
);
  logic [CHK_W-1:0]  fresh_chk;
  logic [CHK_W-1:0]  syndrome;
  logic              col_hit;
  logic [POS_W-1:0]  col_pos;
  fault_e            fault;
  logic [POS_W-1:0]  fault_pos;
  logic [DATA_W-1:0] fix_data;
  logic [CHK_W-1:0]  fix_chk;

  secded_chk_gen u_gen (.data(in_data), .check(fresh_chk));

  assign syndrome = fresh_chk ^ in_check;

  secded_col_match u_match (
    .syndrome(syndrome), .hit_any(col_hit), .hit_pos(col_pos)
  );

  secded_classify u_cls (
    .syndrome(syndrome), .hit_any(col_hit), .hit_pos(col_pos),
    .status(fault), .pos(fault_pos)
  );

  always_comb begin
    fix_data = in_data;
    fix_chk  = in_check;
    if (fault == FLT_DATA)  fix_data[fault_pos] = ~in_data[fault_pos];
    if (fault == FLT_CHECK) fix_chk[fault_pos[2:0]] = ~in_check[fault_pos[2:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_status <= '0;
      out_pos    <= '0;
      out_data   <= '0;
      out_check  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_status <= fault;
        out_pos    <= fault_pos;
        out_data   <= fix_data;
        out_check  <= fix_chk;
      end
    end
  end

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_check) && $stable(out_status) && $stable(out_pos)));
  a_r2_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == 2'd0) |->
      (out_data == $past(in_data) && out_check == $past(in_check) && out_pos == '0));
  a_r3_one_data_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == 2'd1) |->
      ($countones(out_data ^ $past(in_data)) == 1 && out_check == $past(in_check)));
  a_r4_one_check_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == 2'd2) |->
      ($countones(out_check ^ $past(in_check)) == 1 && out_data == $past(in_data)));
  a_r5_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == 2'd3) |->
      (out_data == $past(in_data) && out_check == $past(in_check) && out_pos == '0));
  a_r1_repaired_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status != 2'd3) |-> (calc_check(out_data) == out_check));
endmodule

// File: tb/secded_decoder_tb.sv
module secded_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_check = '0;
  logic        out_valid;
  logic [1:0]  out_status;
  logic [5:0]  out_pos;
  logic [63:0] out_data;
  logic [7:0]  out_check;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  secded_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_check(in_check), .out_valid(out_valid), .out_status(out_status),
    .out_pos(out_pos), .out_data(out_data), .out_check(out_check)
  );

  // bench copy of the mask pairs as 64-bit rows {high, low}
  function automatic logic [63:0] row(input int i);
    case (i)
      0: return 64'hf00fe11e_c33c0ff7;
      1: return 64'h00ff00ff_00fff0ff;
      2: return 64'h0f0f0f0f_0f0fff00;
      3: return 64'h11113333_7777000f;
      4: return 64'h22224444_8888222f;
      5: return 64'h44448888_ffff4441;
      6: return 64'h8888ffff_11118882;
      default: return 64'hffff1111_22221114;
    endcase
  endfunction

  function automatic logic [7:0] mchk(input logic [63:0] d);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      logic [63:0] m = row(i);
      for (int j = 0; j < 64; j++)
        if (m[j] && d[j]) r[i] = ~r[i];
    end
    return r;
  endfunction

  task automatic model(input logic [63:0] d, input logic [7:0] c,
                       output logic [1:0] st, output logic [5:0] p,
                       output logic [63:0] od, output logic [7:0] oc);
    logic [7:0] s = mchk(d) ^ c;
    bit found = 0;
    st = 2'd0; p = '0; od = d; oc = c;
    if (s != 0) begin
      for (int b = 0; b < 64; b++)
        if (!found && mchk(64'd1 << b) == s) begin
          found = 1; st = 2'd1; p = 6'(b); od = d ^ (64'd1 << b);
        end
      if (!found) begin
        if ($countones(s) == 1) begin
          st = 2'd2;
          for (int k = 0; k < 8; k++) if (s[k]) p = 6'(k);
          oc = c ^ s;
        end else st = 2'd3;
      end
    end
  endtask

  task automatic apply(input logic [63:0] d, input logic [7:0] c);
    logic [1:0] es; logic [5:0] ep; logic [63:0] ed; logic [7:0] ec;
    string tag;
    in_data = d; in_check = c; in_valid = 1'b1;
    @(negedge clk);
    model(d, c, es, ep, ed, ec);
    case (es)
      2'd0: tag = "R1 R2 R6";
      2'd1: tag = "R1 R3 R6";
      2'd2: tag = "R1 R4 R6";
      default: tag = "R1 R5 R6";
    endcase
    n_chk++;
    if (out_valid !== 1'b1 || out_status !== es || out_pos !== ep ||
        out_data !== ed || out_check !== ec) begin
      n_fail++;
      $display("FAIL %s: got v=%b st=%0d pos=%0d d=%h c=%h exp v=1 st=%0d pos=%0d d=%h c=%h",
               tag, out_valid, out_status, out_pos, out_data, out_check, es, ep, ed, ec);
    end
  endtask

  task automatic idle_check(input logic [63:0] junk);
    logic [1:0] st = out_status; logic [5:0] p = out_pos;
    logic [63:0] d = out_data; logic [7:0] c = out_check;
    in_valid = 1'b0; in_data = junk; in_check = ~junk[7:0];
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_status !== st || out_pos !== p ||
        out_data !== d || out_check !== c) begin
      n_fail++;
      $display("FAIL R6 hold: got v=%b st=%0d d=%h c=%h exp v=0 st=%0d d=%h c=%h",
               out_valid, out_status, out_data, out_check, st, d, c);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] words [6];
    words[0] = 64'h0;
    words[1] = ~64'h0;
    words[2] = 64'ha5a5_5a5a_c3c3_3c3c;
    words[3] = 64'h0123_4567_89ab_cdef;
    words[4] = 64'hdead_beef_0bad_f00d;
    words[5] = 64'h8000_0001_7fff_fffe;

    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 0 || out_status !== 0 || out_pos !== 0 ||
        out_data !== 0 || out_check !== 0) begin
      n_fail++;
      $display("FAIL R7 reset: got v=%b st=%0d pos=%0d d=%h c=%h exp all zero",
               out_valid, out_status, out_pos, out_data, out_check);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int w = 0; w < 6; w++) begin
      logic [63:0] d = words[w];
      logic [7:0]  c = mchk(d);
      apply(d, c);                                   // clean word
      for (int b = 0; b < 64; b++) apply(d ^ (64'd1 << b), c);   // single data faults
      for (int k = 0; k < 8; k++) apply(d, c ^ (8'd1 << k));     // single check faults
      for (int b = 0; b < 64; b += 8) apply(d ^ (64'd3 << b), c); // adjacent doubles
      apply(d ^ 64'd1, c ^ 8'h80);
      apply(d ^ (64'd1 << 40), c ^ 8'h01);
      apply(d, c ^ 8'h11);
      apply(d, c ^ 8'hff);
      apply(d, 8'h00);                               // arbitrary check byte
      idle_check(~d);
    end

    idle_check(64'h1234);
    idle_check(64'h5678);

    // reset after activity clears the outputs again
    rst_n = 1'b0;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 0 || out_status !== 0 || out_data !== 0 || out_check !== 0) begin
      n_fail++;
      $display("FAIL R7 re-reset: got v=%b st=%0d d=%h c=%h exp all zero",
               out_valid, out_status, out_data, out_check);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule